// File: doc/BRIEF.md
# Chip-Select Control Latch

This block lets several card-interface controllers hang off one shared set of host lines. Each controller has its own select input. While the synchronized select is high, the host's seven control lines pass straight through to the controller's internal logic. The host-side copies of the card data lines are driven from the card side wherever their enable bit is set, and the status flag is driven out. The seven control lines are reset request, activation command, mode, voltage select, two clock-divider selects and external strobe.

When select drops, the controller keeps the control levels it saw at that moment, so the host can talk to another controller without disturbing this one. In the same cycle every host-side data copy and the status flag stop driving. Select is asynchronous to the internal clock, so it passes through a two-flop synchronizer first. Each tri-stated line is modelled as a value and output-enable pair.

Top module: `csel_latch`

## Requirements
- R1: After reset the block acts as deselected. The control outputs show the safe word: `ctl_rst_req`=1 and `ctl_act_cmd`, `ctl_mode`, `ctl_vsel`, `ctl_div_a`, `ctl_div_b` and `ctl_strobe` all 0. `stat_oe`=0, and every bit of `host_dat_oe` and `host_dat_o` is 0.
- R2: A change on `sel_in` reaches the block's behaviour on the second rising clock edge after it. After only one edge, the block still behaves as before the change.
- R3: While selected, each control output equals its host input in the same cycle, with no clock delay.
- R4: When the synchronized select falls, the control outputs take the host input levels sampled at that same clock edge.
- R5: While deselected, changes on the host control inputs have no effect on the control outputs.
- R6: While selected, line i has `host_dat_oe[i]` = `mirror_en[i]`. Where that bit is 1, `host_dat_o[i]` equals `card_dat_i[i]`. Where it is 0, `host_dat_o[i]` is 0.
- R7: While deselected, every bit of `host_dat_oe` and `host_dat_o` is 0, whatever `mirror_en` and `card_dat_i` hold.
- R8: `stat_oe` is 1 exactly while selected. `stat_o` then follows `stat_i` and is 0 otherwise.
- R9: When select returns high, pass-through of the control inputs resumes, and the held word no longer reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 1 | Asynchronous select from the host |
| h_rst_req | input | 1 | Host reset request |
| h_act_cmd | input | 1 | Host activation command |
| h_mode | input | 1 | Host mode select |
| h_vsel | input | 1 | Host voltage select |
| h_div_a | input | 1 | Host clock-divider select A |
| h_div_b | input | 1 | Host clock-divider select B |
| h_strobe | input | 1 | Host external strobe |
| ctl_rst_req | output | 1 | Reset request to internal logic |
| ctl_act_cmd | output | 1 | Activation command to internal logic |
| ctl_mode | output | 1 | Mode to internal logic |
| ctl_vsel | output | 1 | Voltage select to internal logic |
| ctl_div_a | output | 1 | Divider select A to internal logic |
| ctl_div_b | output | 1 | Divider select B to internal logic |
| ctl_strobe | output | 1 | Strobe to internal logic |
| card_dat_i | input | N_LINES | Card-side data lines (I/O and two auxiliaries) |
| mirror_en | input | N_LINES | Per-line enable for the host-side copies |
| host_dat_o | output | N_LINES | Host-side copy values |
| host_dat_oe | output | N_LINES | Host-side copy output enables |
| stat_i | input | 1 | Internal status flag |
| stat_o | output | 1 | Status flag value |
| stat_oe | output | 1 | Status flag output enable |

## Verification
On every cycle the assertions check several properties: the two-edge select delay, pass-through while selected, stability of the control outputs through a deselected stretch, capture at the falling select, and tri-stating of the mirrors and status flag. Other behaviours only show up in the bench's scenarios. These are the safe reset word, an input change landing exactly on the capturing edge being kept while a change one edge later is ignored, mixed per-line enable patterns, and a clean return to pass-through after reselection.

// File: rtl/csel_latch.sv
module csel_latch #(
  parameter int N_LINES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_in,
  input  logic               h_rst_req,
  input  logic               h_act_cmd,
  input  logic               h_mode,
  input  logic               h_vsel,
  input  logic               h_div_a,
  input  logic               h_div_b,
  input  logic               h_strobe,
  output logic               ctl_rst_req,
  output logic               ctl_act_cmd,
  output logic               ctl_mode,
  output logic               ctl_vsel,
  output logic               ctl_div_a,
  output logic               ctl_div_b,
  output logic               ctl_strobe,
  input  logic [N_LINES-1:0] card_dat_i,
  input  logic [N_LINES-1:0] mirror_en,
  output logic [N_LINES-1:0] host_dat_o,
  output logic [N_LINES-1:0] host_dat_oe,
  input  logic               stat_i,
  output logic               stat_o,
  output logic               stat_oe
);

  localparam int         CTL_W = 7;
  localparam logic [CTL_W-1:0] SAFE_WORD = 7'b000_0001;

  logic [1:0]       sel_sync;
  logic             sel_s;
  logic [CTL_W-1:0] host_word;
  logic [CTL_W-1:0] held;
  logic [CTL_W-1:0] ctl_word;

  assign sel_s     = sel_sync[1];
  assign host_word = {h_strobe, h_div_b, h_div_a, h_vsel, h_mode, h_act_cmd, h_rst_req};
  assign ctl_word  = sel_s ? host_word : held;

  assign {ctl_strobe, ctl_div_b, ctl_div_a, ctl_vsel, ctl_mode, ctl_act_cmd, ctl_rst_req} = ctl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sync <= 2'b00;
      held     <= SAFE_WORD;
    end else begin
      sel_sync <= {sel_sync[0], sel_in};
      if (sel_s) held <= host_word;
    end
  end

  assign host_dat_oe = sel_s ? mirror_en : '0;
  assign host_dat_o  = card_dat_i & host_dat_oe;
  assign stat_oe     = sel_s;
  assign stat_o      = sel_s & stat_i;

  // assertion support: edges seen since reset release, saturating at 2
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_cnt <= 2'd0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
  end

  logic [CTL_W-1:0] ctl_port;
  assign ctl_port = {ctl_strobe, ctl_div_b, ctl_div_a, ctl_vsel, ctl_mode, ctl_act_cmd, ctl_rst_req};

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == 2'd2) |-> (stat_oe == $past(sel_in, 2)));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_oe |-> (ctl_port == host_word));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_oe) |-> (ctl_port == $past(host_word)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_oe && $past(!stat_oe)) |-> $stable(ctl_port));

  assert_mirror_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_dat_oe & ~mirror_en) == '0) && ((host_dat_o & ~host_dat_oe) == '0));

  assert_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_oe |-> (host_dat_oe == '0 && host_dat_o == '0 && !stat_o));

endmodule

// File: tb/csel_latch_tb.sv
module csel_latch_tb;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, sel_in = 0;
  logic [6:0] hw = '0;
  logic [N-1:0] card = '0, men = '0;
  logic stat_i = 0;
  logic [6:0] ctl;
  logic [N-1:0] hdo, hoe;
  logic so, soe;

  always #4 clk = ~clk;

  csel_latch #(.N_LINES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in),
    .h_rst_req(hw[0]), .h_act_cmd(hw[1]), .h_mode(hw[2]), .h_vsel(hw[3]),
    .h_div_a(hw[4]), .h_div_b(hw[5]), .h_strobe(hw[6]),
    .ctl_rst_req(ctl[0]), .ctl_act_cmd(ctl[1]), .ctl_mode(ctl[2]), .ctl_vsel(ctl[3]),
    .ctl_div_a(ctl[4]), .ctl_div_b(ctl[5]), .ctl_strobe(ctl[6]),
    .card_dat_i(card), .mirror_en(men), .host_dat_o(hdo), .host_dat_oe(hoe),
    .stat_i(stat_i), .stat_o(so), .stat_oe(soe)
  );

  typedef struct {
    string      req;
    logic [6:0] ctl;
    logic [N-1:0] dat, oe;
    logic       so, soe;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic push(string req, logic [6:0] c, logic [N-1:0] d, logic [N-1:0] e, logic s, logic se);
    exp_t x;
    x.req = req; x.ctl = c; x.dat = d; x.oe = e; x.so = s; x.soe = se;
    q.push_back(x);
    @(negedge clk); #1;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_chk++;
      if (ctl !== x.ctl || hdo !== x.dat || hoe !== x.oe || so !== x.so || soe !== x.soe) begin
        n_fail++;
        $display("FAIL %s: got ctl=%b dat=%b oe=%b so=%b soe=%b exp ctl=%b dat=%b oe=%b so=%b soe=%b",
                 x.req, ctl, hdo, hoe, so, soe, x.ctl, x.dat, x.oe, x.so, x.soe);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with noisy inputs
    hw = 7'b1111110; card = 3'b111; men = 3'b111; stat_i = 1;
    step(2);
    push("R1 in reset", 7'b0000001, 3'b000, 3'b000, 1'b0, 1'b0);
    rst_n = 1;
    step(2);
    push("R1 after reset", 7'b0000001, 3'b000, 3'b000, 1'b0, 1'b0);

    // R2 select latency
    step(1);
    sel_in = 1; hw = 7'b0101010;
    push("R2 zero edges", 7'b0000001, 3'b000, 3'b000, 1'b0, 1'b0);
    step(1);
    push("R2 one edge", 7'b0000001, 3'b000, 3'b000, 1'b0, 1'b0);
    step(1);
    push("R2 two edges", 7'b0101010, 3'b111, 3'b111, 1'b1, 1'b1);

    // R3 pass-through, several patterns, same cycle
    step(1);
    hw = 7'b1010101; card = 3'b010; men = 3'b111; stat_i = 0;
    push("R3 pattern a", 7'b1010101, 3'b010, 3'b111, 1'b0, 1'b1);
    hw = 7'b0011100;
    push("R3 pattern b", 7'b0011100, 3'b010, 3'b111, 1'b0, 1'b1);

    // R6 per-line enables
    men = 3'b101; card = 3'b111; stat_i = 1;
    push("R6 en 101", 7'b0011100, 3'b101, 3'b101, 1'b1, 1'b1);
    men = 3'b010; card = 3'b101;
    push("R6 en 010 low data", 7'b0011100, 3'b000, 3'b010, 1'b1, 1'b1);
    men = 3'b110; card = 3'b010;
    push("R6 en 110", 7'b0011100, 3'b010, 3'b110, 1'b1, 1'b1);

    // R4 capture exactly at the falling synchronized edge
    step(1);
    hw = 7'b1100110; sel_in = 0;
    push("R4 pre edge1", 7'b1100110, 3'b010, 3'b110, 1'b1, 1'b1);
    step(1);
    hw = 7'b0110011;
    push("R4 still selected after edge1", 7'b0110011, 3'b010, 3'b110, 1'b1, 1'b1);
    step(1);
    push("R4 captured word", 7'b0110011, 3'b000, 3'b000, 1'b0, 1'b0);

    // R5 ignore host changes while deselected; R7/R8 tri-state
    hw = 7'b1001100;
    push("R5 change a", 7'b0110011, 3'b000, 3'b000, 1'b0, 1'b0);
    step(3);
    hw = 7'b1111111; men = 3'b111; card = 3'b111; stat_i = 1;
    push("R7 R8 deselected all on", 7'b0110011, 3'b000, 3'b000, 1'b0, 1'b0);
    step(2);
    hw = 7'b0000000;
    push("R5 change b", 7'b0110011, 3'b000, 3'b000, 1'b0, 1'b0);

    // R9 reselect resumes pass-through
    sel_in = 1; hw = 7'b1011001;
    step(1);
    push("R9 one edge still held", 7'b0110011, 3'b000, 3'b000, 1'b0, 1'b0);
    step(1);
    push("R9 resumed", 7'b1011001, 3'b111, 3'b111, 1'b1, 1'b1);
    hw = 7'b0100110; stat_i = 0;
    push("R9 R8 follows", 7'b0100110, 3'b111, 3'b111, 1'b0, 1'b1);

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule